// File: doc/BRIEF.md
# Next-PC and Link Computation Unit

This block chooses the address of the next instruction for a simple 32-bit RISC core. It takes the current program counter, a decoded control-class code, a raw offset field, one register operand for zero tests, one register holding a jump target and the floating-point condition flag. From these it selects the next program counter and raises a redirect flag whenever control flow leaves the sequential path. Jump-and-link classes also request a write of the return address into register 31.

All outputs are registered, so every result appears one clock after the inputs are presented. Ordinary instructions step the counter by 4. Conditional branches test a single register against zero or test the floating-point flag; they do not compare two registers. The branch offset is the low 16 bits of the offset field and the jump offset is the whole 26-bit field. Both are sign-extended and added to PC+4. All address arithmetic wraps modulo 2^32.

Top module: `next_pc_unit`

## Requirements
- R1: While rst_n is low, next_pc_o, redirect_o, link_we_o and link_val_o read zero.
- R2: Class 0 (sequential) and every class code from 9 to 15 give next_pc_o = PC+4 with redirect_o and link_we_o low, one clock after the inputs.
- R3: Class 1 (branch if zero) redirects to PC+4+sext(offset[15:0]) when test_val_i is zero. Otherwise it gives PC+4 with redirect_o low.
- R4: Class 2 (branch if non-zero) redirects to PC+4+sext(offset[15:0]) when test_val_i is non-zero. Otherwise it gives PC+4 with redirect_o low.
- R5: Class 3 (jump) always redirects to PC+4+sext(offset[25:0]).
- R6: Class 4 (jump and link) redirects like class 3 and raises link_we_o, with link_idx_o = 31 and link_val_o = PC+4.
- R7: Class 5 (register jump) redirects to jump_reg_i. Class 6 (register jump and link) does the same and also raises link_we_o with link_val_o = PC+4.
- R8: Class 7 redirects to the branch target when fp_cond_i is 1, and class 8 redirects to it when fp_cond_i is 0. In the other case each gives PC+4 with redirect_o low.
- R9: link_we_o is high only for classes 4 and 6. link_val_o always equals the PC+4 of the instruction that produced it.
- R10: All sums wrap modulo 2^32. A PC of 0xFFFFFFFC steps to 0, and negative offsets are able to cross address 0.
- R11: For the branch classes (1, 2, 7, 8), offset bits 25:16 have no effect on next_pc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | Current program counter |
| kind_i | input | 4 | Control-class code |
| offset_i | input | 26 | Raw offset field; the low 16 bits serve as the branch offset |
| test_val_i | input | 32 | Register value tested against zero |
| jump_reg_i | input | 32 | Register value used as the target of a register jump |
| fp_cond_i | input | 1 | Floating-point condition flag |
| next_pc_o | output | 32 | Selected next program counter |
| redirect_o | output | 1 | High when next_pc_o is not PC+4 because of a taken transfer |
| link_we_o | output | 1 | Request to write the link register |
| link_idx_o | output | 5 | Link register index, fixed at 31 |
| link_val_o | output | 32 | Return address PC+4 |

## Verification
A wrong class decode or a wrong taken condition shows up at next_pc_o and redirect_o on the very next clock. There it appears either as a PC+4 where a target was due or as a target where PC+4 was due. A sign-extension or field-width error only shows for offsets with the top bit set or with bits 25:16 set, so those patterns are swept for every class. A stray link request shows as link_we_o high one cycle after a class that does not link.

// File: rtl/next_pc_unit.sv
module next_pc_unit #(
  parameter int XLEN     = 32,
  parameter int KIND_W   = 4,
  parameter int BOFF_W   = 16,
  parameter int JOFF_W   = 26,
  parameter int RIDX_W   = 5,
  parameter int LINK_REG = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [KIND_W-1:0] kind_i,
  input  logic [JOFF_W-1:0] offset_i,
  input  logic [XLEN-1:0]   test_val_i,
  input  logic [XLEN-1:0]   jump_reg_i,
  input  logic              fp_cond_i,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              redirect_o,
  output logic              link_we_o,
  output logic [RIDX_W-1:0] link_idx_o,
  output logic [XLEN-1:0]   link_val_o
);
  localparam logic [XLEN-1:0]   STEP    = XLEN'(4);
  localparam logic [KIND_W-1:0] K_BEQZ  = KIND_W'(1);
  localparam logic [KIND_W-1:0] K_BNEZ  = KIND_W'(2);
  localparam logic [KIND_W-1:0] K_JMP   = KIND_W'(3);
  localparam logic [KIND_W-1:0] K_JAL   = KIND_W'(4);
  localparam logic [KIND_W-1:0] K_JR    = KIND_W'(5);
  localparam logic [KIND_W-1:0] K_JALR  = KIND_W'(6);
  localparam logic [KIND_W-1:0] K_FPT   = KIND_W'(7);
  localparam logic [KIND_W-1:0] K_FPF   = KIND_W'(8);

  logic [XLEN-1:0] seq_pc, br_tgt, jp_tgt, nxt;
  logic            is_zero, take, link;

  assign seq_pc  = pc_i + STEP;
  assign br_tgt  = seq_pc + {{(XLEN-BOFF_W){offset_i[BOFF_W-1]}}, offset_i[BOFF_W-1:0]};
  assign jp_tgt  = seq_pc + {{(XLEN-JOFF_W){offset_i[JOFF_W-1]}}, offset_i};
  assign is_zero = (test_val_i == '0);

  always_comb begin
    take = 1'b1;
    link = 1'b0;
    nxt  = seq_pc;
    case (kind_i)
      K_BEQZ: begin take = is_zero;    nxt = br_tgt; end
      K_BNEZ: begin take = !is_zero;   nxt = br_tgt; end
      K_FPT:  begin take = fp_cond_i;  nxt = br_tgt; end
      K_FPF:  begin take = !fp_cond_i; nxt = br_tgt; end
      K_JMP:  nxt = jp_tgt;
      K_JAL:  begin nxt = jp_tgt; link = 1'b1; end
      K_JR:   nxt = jump_reg_i;
      K_JALR: begin nxt = jump_reg_i; link = 1'b1; end
      default: take = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_pc_o  <= '0;
      redirect_o <= 1'b0;
      link_we_o  <= 1'b0;
      link_val_o <= '0;
    end else begin
      next_pc_o  <= take ? nxt : seq_pc;
      redirect_o <= take;
      link_we_o  <= link;
      link_val_o <= seq_pc;
    end
  end

  assign link_idx_o = RIDX_W'(LINK_REG);
endmodule

// File: rtl/next_pc_unit_chk.sv
module next_pc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int KIND_W = 4,
  parameter int JOFF_W = 26
) (
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   pc_i,
  input logic [KIND_W-1:0] kind_i,
  input logic [JOFF_W-1:0] offset_i,
  input logic [XLEN-1:0]   jump_reg_i,
  input logic              fp_cond_i,
  input logic [XLEN-1:0]   next_pc_o,
  input logic              redirect_o,
  input logic              link_we_o,
  input logic [XLEN-1:0]   link_val_o
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  p_seq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(kind_i) == KIND_W'(0) |-> next_pc_o == $past(pc_i) + 32'd4 && !redirect_o);

  p_notaken_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && !redirect_o |-> next_pc_o == $past(pc_i) + 32'd4);

  p_link_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    armed && link_we_o |-> $past(kind_i) == KIND_W'(4) || $past(kind_i) == KIND_W'(6));

  p_link_val_r6: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> link_val_o == $past(pc_i) + 32'd4);

  p_jr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(kind_i) == KIND_W'(5) |-> redirect_o && next_pc_o == $past(jump_reg_i));

  p_fpt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(kind_i) == KIND_W'(7) |-> redirect_o == $past(fp_cond_i));

  p_jmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    armed && $past(kind_i) == KIND_W'(3) |-> redirect_o && !link_we_o);

  logic unused;
  assign unused = ^offset_i;
endmodule

bind next_pc_unit next_pc_unit_chk #(.XLEN(XLEN), .KIND_W(KIND_W), .JOFF_W(JOFF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pc_i(pc_i), .kind_i(kind_i), .offset_i(offset_i),
  .jump_reg_i(jump_reg_i), .fp_cond_i(fp_cond_i), .next_pc_o(next_pc_o),
  .redirect_o(redirect_o), .link_we_o(link_we_o), .link_val_o(link_val_o));

// File: tb/tb_next_pc_unit.sv
`timescale 1ns/1ps
module tb_next_pc_unit;
  logic        clk = 0, rst_n = 0;
  logic [31:0] pc, tval, jreg;
  logic [3:0]  kind;
  logic [25:0] off;
  logic        fp;
  logic [31:0] npc, lval;
  logic        red, lwe;
  logic [4:0]  lidx;
  int vectors = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  next_pc_unit dut (.clk(clk), .rst_n(rst_n), .pc_i(pc), .kind_i(kind), .offset_i(off),
    .test_val_i(tval), .jump_reg_i(jreg), .fp_cond_i(fp), .next_pc_o(npc),
    .redirect_o(red), .link_we_o(lwe), .link_idx_o(lidx), .link_val_o(lval));

  function automatic string tag_of(logic [3:0] k);
    case (k)
      1: return "R3";  2: return "R4";  3: return "R5";  4: return "R6";
      5, 6: return "R7";  7, 8: return "R8";  default: return "R2";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] en, logic er, logic ew, logic [31:0] ev);
    vectors++;
    if (npc !== en || red !== er || lwe !== ew || lval !== ev || lidx !== 5'd31) begin
      errors++;
      $display("FAIL %s: kind=%0d pc=%h off=%h npc=%h red=%b we=%b val=%h idx=%0d expected npc=%h red=%b we=%b val=%h idx=31",
               tag, kind, pc, off, npc, red, lwe, lval, lidx, en, er, ew, ev);
    end
  endtask

  task automatic apply(string tag, logic [3:0] k, logic [31:0] p, logic [25:0] o,
                       logic [31:0] t, logic [31:0] j, logic f);
    logic [31:0] s, bt, jt, en;
    logic er;
    @(negedge clk);
    kind = k; pc = p; off = o; tval = t; jreg = j; fp = f;
    s  = p + 32'd4;
    bt = s + {{16{o[15]}}, o[15:0]};
    jt = s + {{6{o[25]}}, o};
    er = 1'b0; en = s;
    case (k)
      1: if (t == 0) begin er = 1; en = bt; end
      2: if (t != 0) begin er = 1; en = bt; end
      7: if (f)      begin er = 1; en = bt; end
      8: if (!f)     begin er = 1; en = bt; end
      3, 4: begin er = 1; en = jt; end
      5, 6: begin er = 1; en = j; end
      default: ;
    endcase
    @(posedge clk); #1;
    check(tag, en, er, (k == 4 || k == 6), s);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pcs [4] = '{32'h0000_1000, 32'hFFFF_FFFC, 32'h0000_0000, 32'h7FFF_FFF8};
    logic [25:0] offs[5] = '{26'h0, 26'h000_0040, 26'h3FF_FFF0, 26'h200_8000, 26'h1FF_7FFC};
    kind = 0; pc = 32'h1234; off = 0; tval = 0; jreg = 0; fp = 0;
    repeat (3) @(posedge clk);
    #1;
    vectors++;
    if (npc !== 0 || red !== 0 || lwe !== 0 || lval !== 0) begin
      errors++;
      $display("FAIL R1: npc=%h red=%b we=%b val=%h expected all zero", npc, red, lwe, lval);
    end
    @(negedge clk); rst_n = 1;

    for (int k = 0; k < 16; k++)
      for (int pi = 0; pi < 4; pi++)
        for (int oi = 0; oi < 5; oi++)
          for (int t = 0; t < 2; t++)
            for (int f = 0; f < 2; f++)
              apply(tag_of(4'(k)), 4'(k), pcs[pi], offs[oi], t ? 32'h8000_0000 : 32'h0,
                    32'hABCD_0000 + 32'(pi * 4), f[0]);

    // R9: link request never leaks to the following non-link class
    apply("R9", 4'd4, 32'h100, 26'h10, 0, 0, 0);
    apply("R9", 4'd1, 32'h100, 26'h10, 1, 0, 0);
    apply("R9", 4'd6, 32'h200, 26'h0, 0, 32'h4000, 0);
    apply("R9", 4'd5, 32'h200, 26'h0, 0, 32'h4000, 0);
    // R10: wrap at the top of the address space and negative offset below zero
    apply("R10", 4'd0, 32'hFFFF_FFFC, 26'h0, 0, 0, 0);
    apply("R10", 4'd3, 32'h0000_0000, 26'h3FF_FFF8, 0, 0, 0);
    apply("R10", 4'd1, 32'hFFFF_FFF8, 26'h000_0010, 0, 0, 0);
    // R11: bits 25:16 of the field do not disturb the branch target
    apply("R11", 4'd1, 32'h1000, 26'h3FF_0020, 0, 0, 0);
    apply("R11", 4'd2, 32'h1000, 26'h155_0020, 1, 0, 0);
    apply("R11", 4'd7, 32'h1000, 26'h2AA_FFE0, 0, 0, 1);
    apply("R11", 4'd8, 32'h1000, 26'h3FF_FFE0, 0, 0, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule